// File: doc/BRIEF.md
# Matrix Column Product Array

This block multiplies a square matrix A by one column of a matrix B on each clock, returning one full column of the product matrix C. A grid of DIM by DIM registered multipliers does the work: grid row k receives column k of A, one element per multiplier, and also the single element k of the current B column, which is broadcast to every multiplier in that row. The products standing in each grid column are added to form one element of the result column. A full DIM by DIM product is therefore finished in DIM consecutive cycles by presenting the B columns one after another while A stays in place.

Operands pass through a staging register before the multiplier registers, so the next operand set is already held while the current set is being multiplied. A valid flag travels with the data and the result appears a fixed two cycles after its operands. Smaller matrices are handled by the caller driving the unused rows and columns with zero operands. Sequencing of columns, accumulation over tiles of larger matrices and any memory are outside this block.

Top module: `mmx_col_array`

## Requirements
- R1: While rst_n is low at a rising edge, the block clears itself; in the cycle after such an edge out_valid is 0 and vec_c is all zero.
- R2: out_valid is high exactly two cycles after a cycle in which in_valid was sampled high, and low otherwise.
- R3: Each result element j equals the unsigned sum over k of A[j][k] times b[k], taken from the operands sampled two cycles earlier.
- R4: Field positions: A[j][k] occupies mat_a bits starting at (j*DIM+k)*OP_W, b[k] occupies vec_b bits starting at k*OP_W, and result element j occupies vec_c bits starting at j*SUM_W; with DIM=4, OP_W=16 the result elements are SUM_W=34 bits wide.
- R5: No result element overflows: with every operand at its maximum value 0xFFFF each result element equals 4*0xFFFF*0xFFFF exactly.
- R6: Operand sets presented on consecutive cycles produce results on consecutive cycles with no bubble, so the DIM result columns of a full matrix product emerge in DIM consecutive cycles.
- R7: Operands presented with in_valid low are ignored: while out_valid is low, vec_c keeps the last result column unchanged.
- R8: A smaller matrix product padded with zero rows and columns yields the correct products in the used elements and zero in the unused ones.
- R9: A B column that is all zero, presented with in_valid high, gives an all-zero result column two cycles later regardless of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set on mat_a and vec_b is valid |
| mat_a | input | DIM*DIM*OP_W | Matrix A, element A[j][k] at offset (j*DIM+k)*OP_W |
| vec_b | input | DIM*OP_W | Current column of matrix B, element k at offset k*OP_W |
| out_valid | output | 1 | vec_c carries a new result column |
| vec_c | output | DIM*SUM_W | Result column, element j at offset j*SUM_W |

## Verification
The operand staging of one set and the multiplication of the previous set fall in the same cycle whenever sets arrive back to back, and a gap cycle with junk operands can fall in the same cycle as a result still leaving the multiplier registers. The bench provokes both by streaming whole matrix products one column per cycle, then mixing in idle cycles that carry pseudo-random operands with in_valid low. Each result is judged against a product computed arithmetically in the bench two cycles after its operands, and every idle result cycle is judged against the last valid column, which must not move.

// File: rtl/mmx_pkg.sv
// Package: shared defaults and width helpers for the matrix column array.
// Assumes: operands are unsigned; sums are sized so they cannot overflow.
package mmx_pkg;

    localparam int unsigned MMX_DEF_DIM  = 4;
    localparam int unsigned MMX_DEF_OP_W = 16;

    // Width of one product of two operands.
    function automatic int unsigned mmx_prod_w(input int unsigned op_w);
        return 2 * op_w;
    endfunction

    // Width of a sum of dim products, with headroom bits for the carries.
    function automatic int unsigned mmx_sum_w(input int unsigned op_w, input int unsigned dim);
        return 2 * op_w + $clog2(dim);
    endfunction

endpackage

// File: rtl/mmx_stage.sv
// Module: operand staging register. Captures a full operand set when
// in_valid is high, so the next set is held while the previous one is in
// the multipliers. Assumes: operands are held unchanged when in_valid is low.
module mmx_stage #(
    parameter int unsigned DIM  = 4,
    parameter int unsigned OP_W = 16,
    localparam int unsigned AW  = DIM * DIM * OP_W,
    localparam int unsigned BW  = DIM * OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_a,
    input  logic [BW-1:0] in_b,
    output logic          st_valid,
    output logic [AW-1:0] st_a,
    output logic [BW-1:0] st_b
);

    // Valid flag follows the input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
        end else begin
            st_valid <= in_valid;
        end
    end

    // Operand capture only for accepted sets; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_a <= '0;
            st_b <= '0;
        end else if (in_valid) begin
            st_a <= in_a;
            st_b <= in_b;
        end
    end

endmodule

// File: rtl/mmx_mul_cell.sv
// Module: one registered multiplier of the grid. Loads the product of its
// two operands when enabled, otherwise holds. Assumes unsigned operands.
module mmx_mul_cell #(
    parameter int unsigned OP_W = 16,
    localparam int unsigned PW  = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [OP_W-1:0] op_x,
    input  logic [OP_W-1:0] op_y,
    output logic [PW-1:0]   prod
);

    // Product register, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (en) begin
            prod <= PW'(op_x) * PW'(op_y);
        end
    end

endmodule

// File: rtl/mmx_col_sum.sv
// Module: combinational sum of the DIM products of one grid column.
// Assumes SUM_W has enough headroom for DIM full-scale products.
module mmx_col_sum #(
    parameter int unsigned DIM   = 4,
    parameter int unsigned PW    = 32,
    parameter int unsigned SUM_W = 34
) (
    input  logic [DIM*PW-1:0] prods,
    output logic [SUM_W-1:0]  total
);

    // Add each product widened to the sum width.
    always_comb begin
        total = '0;
        for (int k = 0; k < DIM; k++) begin
            total = total + SUM_W'(prods[k*PW +: PW]);
        end
    end

endmodule

// File: rtl/mmx_col_array.sv
// Module: top of the matrix column product array. Grid row k takes column k
// of A (one element per multiplier) and element k of the B column
// (broadcast along the row); grid column j sums to result element j.
// Latency is two cycles: staging register, then product registers.
// Assumes the caller zero-pads matrices smaller than DIM.
module mmx_col_array
    import mmx_pkg::*;
#(
    parameter int unsigned DIM  = MMX_DEF_DIM,
    parameter int unsigned OP_W = MMX_DEF_OP_W,
    localparam int unsigned PW    = mmx_prod_w(OP_W),
    localparam int unsigned SUM_W = mmx_sum_w(OP_W, DIM),
    localparam int unsigned AW    = DIM * DIM * OP_W,
    localparam int unsigned BW    = DIM * OP_W,
    localparam int unsigned CW    = DIM * SUM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] mat_a,
    input  logic [BW-1:0] vec_b,
    output logic          out_valid,
    output logic [CW-1:0] vec_c
);

    logic          st_valid;
    logic [AW-1:0] st_a;
    logic [BW-1:0] st_b;
    logic          prod_valid;

    // Products gathered per grid column: col_prods[j] holds rows 0..DIM-1.
    logic [DIM*PW-1:0] col_prods [DIM];

    mmx_stage #(
        .DIM  (DIM),
        .OP_W (OP_W)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_a     (mat_a),
        .in_b     (vec_b),
        .st_valid (st_valid),
        .st_a     (st_a),
        .st_b     (st_b)
    );

    // Grid: row k, column j multiplies A[j][k] by b[k].
    for (genvar k = 0; k < DIM; k++) begin : g_row
        for (genvar j = 0; j < DIM; j++) begin : g_col
            mmx_mul_cell #(
                .OP_W (OP_W)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (st_valid),
                .op_x  (st_a[(j*DIM+k)*OP_W +: OP_W]),
                .op_y  (st_b[k*OP_W +: OP_W]),
                .prod  (col_prods[j][k*PW +: PW])
            );
        end
    end

    // Column reduction: one adder per grid column.
    for (genvar j = 0; j < DIM; j++) begin : g_sum
        mmx_col_sum #(
            .DIM   (DIM),
            .PW    (PW),
            .SUM_W (SUM_W)
        ) u_sum (
            .prods (col_prods[j]),
            .total (vec_c[j*SUM_W +: SUM_W])
        );
    end

    // Valid flag aligned with the product registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_valid <= 1'b0;
        end else begin
            prod_valid <= st_valid;
        end
    end

    assign out_valid = prod_valid;

endmodule

// File: rtl/mmx_col_array_chk.sv
// Module: property checker for mmx_col_array, attached by bind below.
// Keeps its own two-cycle history of the input side and compares ports.
module mmx_col_array_chk #(
    parameter int unsigned DIM   = 4,
    parameter int unsigned OP_W  = 16,
    parameter int unsigned SUM_W = 34
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [DIM*OP_W-1:0]  vec_b,
    input logic                 out_valid,
    input logic [DIM*SUM_W-1:0] vec_c
);

    logic [1:0] vld_hist;
    logic [1:0] zero_hist;

    // History of accepted sets and of accepted all-zero B columns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_hist  <= '0;
            zero_hist <= '0;
        end else begin
            vld_hist  <= {vld_hist[0], in_valid};
            zero_hist <= {zero_hist[0], in_valid && (vec_b == '0)};
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && (vec_c == '0)));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_hist[1]);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(vec_c));

    assert_zero_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hist[1] |-> (vec_c == '0));

endmodule

bind mmx_col_array mmx_col_array_chk #(
    .DIM   (DIM),
    .OP_W  (OP_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .vec_b     (vec_b),
    .out_valid (out_valid),
    .vec_c     (vec_c)
);

// File: tb/mmx_col_array_bench.sv
`timescale 1ns/1ps
// Bench: streams matrix products column by column, with gaps, padding and
// edge values; expected columns are computed arithmetically here.
module mmx_col_array_bench;

    localparam int DIM   = 4;
    localparam int OP_W  = 16;
    localparam int SUM_W = 2 * OP_W + $clog2(DIM);
    localparam int AW    = DIM * DIM * OP_W;
    localparam int BW    = DIM * OP_W;
    localparam int CW    = DIM * SUM_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] mat_a = '0;
    logic [BW-1:0] vec_b = '0;
    logic          out_valid;
    logic [CW-1:0] vec_c;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic          pv [2];
    logic [CW-1:0] pc [2];
    string         pt [2];
    logic [CW-1:0] last_c;

    always #4 clk = ~clk;

    mmx_col_array u_mmx_col_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mat_a     (mat_a),
        .vec_b     (vec_b),
        .out_valid (out_valid),
        .vec_c     (vec_c)
    );

    function automatic logic [OP_W-1:0] gen(input int unsigned s, input int unsigned i);
        int unsigned x;
        x = (s * 32'd2654435761) ^ (i * 32'd40503 + 32'd7);
        x = x ^ (x >> 13);
        x = x * 32'd1274126177;
        x = x ^ (x >> 16);
        return x[OP_W-1:0];
    endfunction

    function automatic logic [CW-1:0] ref_col(input logic [AW-1:0] a, input logic [BW-1:0] b);
        logic [CW-1:0] r;
        r = '0;
        for (int j = 0; j < DIM; j++) begin
            longint unsigned acc = 0;
            for (int k = 0; k < DIM; k++) begin
                longint unsigned x = longint'(a[(j*DIM+k)*OP_W +: OP_W]);
                longint unsigned y = longint'(b[k*OP_W +: OP_W]);
                acc += x * y;
            end
            r[j*SUM_W +: SUM_W] = acc[SUM_W-1:0];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: judge the result due now, then present the next set.
    task automatic step(input bit v, input logic [AW-1:0] a, input logic [BW-1:0] b, input string tag);
        @(negedge clk);
        check(out_valid === pv[1], "R2", CW'(out_valid), CW'(pv[1]));
        if (pv[1]) begin
            check(vec_c === pc[1], pt[1], vec_c, pc[1]);
            last_c = pc[1];
        end else begin
            check(vec_c === last_c, "R7", vec_c, last_c);
        end
        pv[1] = pv[0]; pc[1] = pc[0]; pt[1] = pt[0];
        pv[0] = v;     pc[0] = ref_col(a, b); pt[0] = tag;
        in_valid = v;
        mat_a = a;
        vec_b = b;
    endtask

    // Full product A*B: B column c carries B[k][c] from a seed.
    task automatic matrix(input logic [AW-1:0] a, input int unsigned bseed, input string tag);
        for (int c = 0; c < DIM; c++) begin
            logic [BW-1:0] b;
            for (int k = 0; k < DIM; k++) b[k*OP_W +: OP_W] = gen(bseed, k*DIM + c);
            step(1'b1, a, b, tag);
        end
    endtask

    function automatic logic [AW-1:0] rand_a(input int unsigned s);
        logic [AW-1:0] a;
        for (int i = 0; i < DIM*DIM; i++) a[i*OP_W +: OP_W] = gen(s, i);
        return a;
    endfunction

    initial begin
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        pv[0] = 0; pv[1] = 0; pc[0] = '0; pc[1] = '0; pt[0] = ""; pt[1] = "";
        last_c = '0;
        // Reset with junk on the inputs.
        in_valid = 1'b1;
        mat_a = rand_a(99);
        vec_b = '1;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", CW'(out_valid), '0);
        check(vec_c === '0, "R1", vec_c, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R4: distinct element values, one-hot B columns select A columns.
        for (int i = 0; i < DIM*DIM; i++) a[i*OP_W +: OP_W] = OP_W'(i + 1);
        for (int k = 0; k < DIM; k++) begin
            b = '0;
            b[k*OP_W +: OP_W] = 1;
            step(1'b1, a, b, "R4");
        end

        // R5: all operands at maximum value.
        step(1'b1, '1, '1, "R5");
        step(1'b0, '0, '0, "R7");
        step(1'b0, '0, '0, "R7");
        check(vec_c[SUM_W-1:0] === SUM_W'(64'd4 * 64'hFFFF * 64'hFFFF), "R5",
              CW'(vec_c[SUM_W-1:0]), CW'(64'd4 * 64'hFFFF * 64'hFFFF));

        // R6/R3: full products back to back, one column per cycle.
        for (int m = 0; m < 40; m++) begin
            matrix(rand_a(m + 1), m + 500, (m < 4) ? "R6" : "R3");
        end

        // R7: gaps with junk operands between products.
        for (int m = 0; m < 20; m++) begin
            matrix(rand_a(m + 200), m + 700, "R3");
            for (int g = 0; g <= (m % 3); g++) step(1'b0, rand_a(m + 900), '1, "R7");
        end

        // R8: 2x2 and 3x3 products padded with zeros.
        for (int n = 2; n <= 3; n++) begin
            for (int m = 0; m < 6; m++) begin
                a = '0;
                for (int j = 0; j < n; j++)
                    for (int k = 0; k < n; k++)
                        a[(j*DIM+k)*OP_W +: OP_W] = gen(m + 40*n, j*DIM + k);
                for (int c = 0; c < DIM; c++) begin
                    b = '0;
                    if (c < n)
                        for (int k = 0; k < n; k++) b[k*OP_W +: OP_W] = gen(m + 77*n, k*DIM + c);
                    step(1'b1, a, b, "R8");
                end
            end
        end

        // R9: zero B column with full A, between nonzero columns.
        for (int m = 0; m < 6; m++) begin
            step(1'b1, rand_a(m + 300), '1, "R3");
            step(1'b1, rand_a(m + 310), '0, "R9");
        end

        // Flush the pipeline.
        repeat (4) step(1'b0, '0, '0, "R7");

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule